// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves control transfers for a small 8-bit processor core. When the sequencer presents a branch with a one-cycle strobe, the unit selects the next program counter, flags whether control actually moved, and reports how many processor cycles the operation consumes. The possible targets are a 16-bit absolute operand, a target relative to the end of a 2-byte instruction, or an address formed from the A and X register bytes. Instruction fetch and flag generation are handled outside the unit.

Four conditional forms test the carry flag or the zero flag and use the relative target when the test holds. When the test fails, the unit steps past the 2-byte instruction. All results are registered and appear one clock after the strobe. A small state machine has two states, IDLE and REPORT. The ACCEPT transition moves from IDLE to REPORT on a strobe. CHAIN keeps the machine in REPORT when a new strobe arrives back to back. RETIRE returns it to IDLE when no strobe is present. The unit stays in IDLE while there is no strobe.

Top module: `branch_resolve_unit`

## Requirements
- R1: After reset, out_valid_o, taken_o, next_pc_o and cycles_o are all zero.
- R2: out_valid_o is high exactly in the cycle after a cycle in which in_valid_i is high. When no strobe is accepted, next_pc_o, taken_o and cycles_o keep their previous values.
- R3: Kind code 0 (absolute) gives next_pc_o = operand, taken_o = 1 and cycles_o = 6.
- R4: Kind code 1 (relative) gives next_pc_o = pc + 2 + the sign-extended 8-bit displacement, taken_o = 1 and cycles_o = 6.
- R5: Kind code 2 (register-indirect) gives next_pc_o = {A, X}, with A as the high byte, taken_o = 1 and cycles_o = 8.
- R6: Kind codes 3, 4, 5 and 6 are taken when carry = 1, carry = 0, zero = 1 and zero = 0 respectively. A taken conditional gives the relative target and cycles_o = 6.
- R7: A conditional branch whose test fails gives next_pc_o = pc + 2, taken_o = 0 and cycles_o = 6.
- R8: All target arithmetic wraps modulo 2^16. No overflow indication is produced.
- R9: Kind code 7 is reserved and behaves like a failed conditional: pc + 2, taken_o = 0, cycles_o = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| in_valid_i | input | 1 | Branch strobe |
| kind_i | input | 3 | Branch kind code |
| pc_i | input | 16 | Address of the branch instruction |
| opnd_i | input | 16 | Absolute target operand |
| disp_i | input | 8 | Signed displacement |
| a_i | input | 8 | A register byte |
| x_i | input | 8 | X register byte |
| cy_i | input | 1 | Carry flag |
| z_i | input | 1 | Zero flag |
| out_valid_o | output | 1 | Result valid, one cycle after the strobe |
| next_pc_o | output | 16 | Resolved next program counter |
| taken_o | output | 1 | Control transfer happened |
| cycles_o | output | 4 | Cycle count of the operation |

## Verification
The relative target is tried with positive, negative and most-negative displacements, so that a missing sign extension or a wrong base offset produces a wrong address. Displacements that carry past 0xFFFF or borrow below 0x0000 expose arithmetic that does not wrap modulo 2^16. Each conditional kind is run with its flag both set and clear, which catches swapped polarities and swapped flags. Absolute and register-indirect cases use operands whose byte halves differ, which catches byte-order mistakes and wrong cycle counts. Back-to-back strobes and idle cycles show whether results are registered and held correctly.

// File: rtl/bru_pkg.sv
package bru_pkg;
    typedef enum logic [2:0] {
        BK_ABS        = 3'd0,
        BK_REL        = 3'd1,
        BK_REG        = 3'd2,
        BK_IF_CARRY   = 3'd3,
        BK_IF_NOCARRY = 3'd4,
        BK_IF_ZERO    = 3'd5,
        BK_IF_NONZERO = 3'd6,
        BK_RSVD       = 3'd7
    } branch_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } bru_state_e;
endpackage

// File: rtl/bru_target.sv
module bru_target #(
    parameter int PC_W    = 16,
    parameter int DISP_W  = 8,
    parameter int REL_LEN = 2
) (
    input  logic [PC_W-1:0]     pc_i,
    input  logic [PC_W-1:0]     opnd_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [PC_W/2-1:0]   a_i,
    input  logic [PC_W/2-1:0]   x_i,
    output logic [PC_W-1:0]     abs_o,
    output logic [PC_W-1:0]     rel_o,
    output logic [PC_W-1:0]     reg_o,
    output logic [PC_W-1:0]     fall_o
);
    localparam int EXT_W = PC_W - DISP_W;

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] end_of_insn;

    // Sign extension of the displacement; sums truncate to PC_W (wrap, R8)
    assign disp_ext    = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    assign end_of_insn = pc_i + PC_W'(REL_LEN);
    assign abs_o       = opnd_i;
    assign rel_o       = end_of_insn + disp_ext;
    assign reg_o       = {a_i, x_i};
    assign fall_o      = end_of_insn;
endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  branch_kind_e kind_i,
    input  logic         cy_i,
    input  logic         z_i,
    output logic         taken_o,
    output logic         indirect_o
);
    always_comb begin
        taken_o    = 1'b0;
        indirect_o = 1'b0;
        unique case (kind_i)
            BK_ABS:        taken_o = 1'b1;
            BK_REL:        taken_o = 1'b1;
            BK_REG: begin
                taken_o    = 1'b1;
                indirect_o = 1'b1;
            end
            BK_IF_CARRY:   taken_o = cy_i;
            BK_IF_NOCARRY: taken_o = ~cy_i;
            BK_IF_ZERO:    taken_o = z_i;
            BK_IF_NONZERO: taken_o = ~z_i;
            BK_RSVD:       taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import bru_pkg::*;
#(
    parameter int PC_W         = 16,
    parameter int DISP_W       = 8,
    parameter int CYC_W        = 4,
    parameter int REL_LEN      = 2,
    parameter int CYC_DIRECT   = 6,
    parameter int CYC_INDIRECT = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                in_valid_i,
    input  logic [2:0]          kind_i,
    input  logic [PC_W-1:0]     pc_i,
    input  logic [PC_W-1:0]     opnd_i,
    input  logic [DISP_W-1:0]   disp_i,
    input  logic [PC_W/2-1:0]   a_i,
    input  logic [PC_W/2-1:0]   x_i,
    input  logic                cy_i,
    input  logic                z_i,
    output logic                out_valid_o,
    output logic [PC_W-1:0]     next_pc_o,
    output logic                taken_o,
    output logic [CYC_W-1:0]    cycles_o
);
    localparam logic [CYC_W-1:0] CYC_D = CYC_W'(CYC_DIRECT);
    localparam logic [CYC_W-1:0] CYC_I = CYC_W'(CYC_INDIRECT);

    branch_kind_e    kind;
    bru_state_e      state_q, state_d;
    logic [PC_W-1:0] t_abs, t_rel, t_reg, t_fall;
    logic            cond_taken, cond_indirect;
    logic [PC_W-1:0] pc_d;
    logic [CYC_W-1:0] cyc_d;

    assign kind = branch_kind_e'(kind_i);

    bru_target #(.PC_W(PC_W), .DISP_W(DISP_W), .REL_LEN(REL_LEN)) u_target (
        .pc_i   (pc_i),
        .opnd_i (opnd_i),
        .disp_i (disp_i),
        .a_i    (a_i),
        .x_i    (x_i),
        .abs_o  (t_abs),
        .rel_o  (t_rel),
        .reg_o  (t_reg),
        .fall_o (t_fall)
    );

    bru_cond u_cond (
        .kind_i     (kind),
        .cy_i       (cy_i),
        .z_i        (z_i),
        .taken_o    (cond_taken),
        .indirect_o (cond_indirect)
    );

    // Target and cycle selection
    always_comb begin
        unique case (kind)
            BK_ABS:  pc_d = t_abs;
            BK_REG:  pc_d = t_reg;
            default: pc_d = cond_taken ? t_rel : t_fall;
        endcase
        cyc_d = cond_indirect ? CYC_I : CYC_D;
    end

    // Next-state logic: ACCEPT, CHAIN, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid_i) state_d = ST_REPORT;
            ST_REPORT: state_d = in_valid_i ? ST_REPORT : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            next_pc_o <= '0;
            taken_o   <= 1'b0;
            cycles_o  <= '0;
        end else if (in_valid_i) begin
            next_pc_o <= pc_d;
            taken_o   <= cond_taken;
            cycles_o  <= cyc_d;
        end
    end

    assign out_valid_o = (state_q == ST_REPORT);

    // Assertions
    assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> out_valid_o);
    assert_valid_only_after_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> !out_valid_o);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !in_valid_i |=> ($stable(next_pc_o) && $stable(taken_o) && $stable(cycles_o)));
    assert_abs_taken_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && kind_i == 3'd0) |=> (taken_o && next_pc_o == $past(opnd_i)));
    assert_reg_pair_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && kind_i == 3'd2) |=> (next_pc_o == {$past(a_i), $past(x_i)} && cycles_o == CYC_I));
    assert_fall_through_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        in_valid_i |=> (taken_o || next_pc_o == $past(pc_i) + PC_W'(REL_LEN)));
    assert_rsvd_not_taken_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && kind_i == 3'd7) |=> !taken_o);
    assert_cycle_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> (cycles_o == CYC_D || cycles_o == CYC_I));
endmodule

// File: tb/branch_resolve_unit_test.sv
module branch_resolve_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  kind = '0;
    logic [15:0] pc = '0, opnd = '0;
    logic [7:0]  disp = '0, a = '0, x = '0;
    logic        cy = 1'b0, z = 1'b0;
    logic        out_valid, taken;
    logic [15:0] next_pc;
    logic [3:0]  cycles;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_resolve_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .kind_i(kind),
        .pc_i(pc), .opnd_i(opnd), .disp_i(disp), .a_i(a), .x_i(x),
        .cy_i(cy), .z_i(z), .out_valid_o(out_valid), .next_pc_o(next_pc),
        .taken_o(taken), .cycles_o(cycles)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] k, input logic [15:0] p, input logic [15:0] o,
                         input logic [7:0] d, input logic [7:0] ra, input logic [7:0] rx,
                         input logic c, input logic zz);
        kind = k; pc = p; opnd = o; disp = d; a = ra; x = rx; cy = c; z = zz;
        in_valid = 1'b1;
    endtask

    // One strobe, then result check one cycle later
    task automatic run_op(input string tag, input logic [2:0] k, input logic [15:0] p,
                          input logic [15:0] o, input logic [7:0] d, input logic [7:0] ra,
                          input logic [7:0] rx, input logic c, input logic zz,
                          input logic [15:0] exp_pc, input logic exp_tk, input logic [3:0] exp_cyc);
        @(negedge clk);
        drive(k, p, o, d, ra, rx, c, zz);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " pc"}, 32'(next_pc), 32'(exp_pc));
        check({tag, " taken"}, 32'(taken), 32'(exp_tk));
        check({tag, " cycles"}, 32'(cycles), 32'(exp_cyc));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid", 32'(out_valid), 0);
        check("R1 pc", 32'(next_pc), 0);
        check("R1 taken", 32'(taken), 0);
        check("R1 cycles", 32'(cycles), 0);
    endtask

    task automatic t_absolute();
        run_op("R3 abs", 3'd0, 16'h1234, 16'hBEEF, 8'h00, 8'h00, 8'h00, 0, 0, 16'hBEEF, 1, 4'd6);
    endtask

    task automatic t_relative();
        run_op("R4 fwd", 3'd1, 16'h1000, 16'h0, 8'h10, 0, 0, 0, 0, 16'h1012, 1, 4'd6);
        run_op("R4 back", 3'd1, 16'h1000, 16'h0, 8'hF0, 0, 0, 0, 0, 16'h0FF2, 1, 4'd6);
        run_op("R4 min", 3'd1, 16'h0100, 16'h0, 8'h80, 0, 0, 0, 0, 16'h0082, 1, 4'd6);
        run_op("R4 self", 3'd1, 16'h2000, 16'h0, 8'hFE, 0, 0, 0, 0, 16'h2000, 1, 4'd6);
    endtask

    task automatic t_wrap();
        run_op("R8 carry out", 3'd1, 16'hFFFF, 16'h0, 8'h05, 0, 0, 0, 0, 16'h0006, 1, 4'd6);
        run_op("R8 borrow", 3'd1, 16'h0000, 16'h0, 8'hF0, 0, 0, 0, 0, 16'hFFF2, 1, 4'd6);
        run_op("R8 fall wrap", 3'd3, 16'hFFFF, 16'h0, 8'h20, 0, 0, 0, 0, 16'h0001, 0, 4'd6);
    endtask

    task automatic t_register();
        run_op("R5 reg", 3'd2, 16'h4000, 16'hAAAA, 8'h33, 8'h12, 8'h34, 0, 0, 16'h1234, 1, 4'd8);
        run_op("R5 reg hi", 3'd2, 16'h0000, 16'h0, 8'h0, 8'hFE, 8'h01, 1, 1, 16'hFE01, 1, 4'd8);
    endtask

    task automatic t_conditional();
        run_op("R6 carry set", 3'd3, 16'h0500, 16'h0, 8'h08, 0, 0, 1, 0, 16'h050A, 1, 4'd6);
        run_op("R7 carry set miss", 3'd3, 16'h0500, 16'h0, 8'h08, 0, 0, 0, 1, 16'h0502, 0, 4'd6);
        run_op("R6 carry clear", 3'd4, 16'h0600, 16'h0, 8'hFC, 0, 0, 0, 1, 16'h05FE, 1, 4'd6);
        run_op("R7 carry clear miss", 3'd4, 16'h0600, 16'h0, 8'hFC, 0, 0, 1, 0, 16'h0602, 0, 4'd6);
        run_op("R6 zero set", 3'd5, 16'h0700, 16'h0, 8'h20, 0, 0, 0, 1, 16'h0722, 1, 4'd6);
        run_op("R7 zero set miss", 3'd5, 16'h0700, 16'h0, 8'h20, 0, 0, 1, 0, 16'h0702, 0, 4'd6);
        run_op("R6 zero clear", 3'd6, 16'h0800, 16'h0, 8'h7F, 0, 0, 1, 0, 16'h0881, 1, 4'd6);
        run_op("R7 zero clear miss", 3'd6, 16'h0800, 16'h0, 8'h7F, 0, 0, 0, 1, 16'h0802, 0, 4'd6);
    endtask

    task automatic t_reserved();
        run_op("R9 rsvd", 3'd7, 16'h3000, 16'h9999, 8'h40, 8'h11, 8'h22, 1, 1, 16'h3002, 0, 4'd6);
    endtask

    task automatic t_hold_and_chain();
        run_op("R2 pre", 3'd2, 16'h0, 16'h0, 8'h0, 8'hC0, 8'hDE, 0, 0, 16'hC0DE, 1, 4'd8);
        // Change inputs without a strobe: nothing should move
        kind = 3'd0; opnd = 16'h5555;
        @(negedge clk);
        check("R2 idle valid", 32'(out_valid), 0);
        check("R2 idle hold pc", 32'(next_pc), 32'h0000C0DE);
        check("R2 idle hold cycles", 32'(cycles), 8);
        // Two strobes back to back
        drive(3'd0, 16'h0, 16'hA001, 8'h0, 0, 0, 0, 0);
        @(negedge clk);
        check("R2 chain1 valid", 32'(out_valid), 1);
        check("R2 chain1 pc", 32'(next_pc), 32'h0000A001);
        drive(3'd4, 16'h0010, 16'h0, 8'h01, 0, 0, 1, 0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 chain2 valid", 32'(out_valid), 1);
        check("R2 chain2 pc", 32'(next_pc), 32'h00000012);
        check("R2 chain2 taken", 32'(taken), 0);
        @(negedge clk);
        check("R2 retire valid", 32'(out_valid), 0);
        check("R2 retire hold", 32'(next_pc), 32'h00000012);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_absolute();
        t_relative();
        t_wrap();
        t_register();
        t_conditional();
        t_reserved();
        t_hold_and_chain();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule